// File: doc/BRIEF.md
# Interrupt-Driven Task Dispatcher

This block sits between a set of peripheral interrupt requests and a small accelerator core. Each of its eight request lines belongs to one task. A request is captured in a pending register, and the dispatcher launches it only when the core is idle and the host has enabled that task. A launch hands the core a start address taken from a per-task vector table, together with the task number.

Tasks run to completion one at a time. A task ends when the core reports that its stop instruction has arrived. The dispatcher then sends the host a single-cycle end-of-task pulse tagged with the task number, and it may start the next pending, enabled task. A one-shot control, meant for debugging, makes each launch clear that task's enable bit. Each task then runs once per enable.

The launch toward the core is a valid/ready handshake. Once the offer (task number and start address) is presented, it stays fixed until the core accepts it. The core may hold the offer off for any number of cycles. The task counts as running from the cycle after acceptance. All other pins are plain control and status.

Top module: `task_dispatcher`

## Requirements
- R1: After reset, launch_valid, busy and eot_pulse are 0, and pending_o and enable_o are all zero.
- R2: A high irq_req bit sampled at a clock edge sets the matching pending_o bit after that edge. A pending bit stays set, without dispatch, for as long as the task's enable bit is 0.
- R3: A dispatch happens at a clock edge where the block is idle and at least one task has both its pending_o bit and its enable_o bit set. launch_valid is high after that edge. Without such a task, launch_valid stays low.
- R4: When several tasks qualify at the dispatch edge, the lowest-numbered task is chosen and appears on launch_id.
- R5: The dispatched task's pending bit is cleared at the dispatch edge. If that task's irq_req bit is high at the same edge, the bit stays set.
- R6: launch_pc carries the vector of the dispatched task. Vector entry k is written when vec_wr is high and vec_idx = k. The vector is captured at the dispatch edge.
- R7: While launch_valid is high and launch_ready is low, launch_valid, launch_id and launch_pc hold their values, and task_stop has no effect.
- R8: After launch_ready is sampled high with launch_valid, the block is running (busy = 1, launch_valid = 0). No other launch occurs until the task ends. Requests that arrive meanwhile only set pending bits.
- R9: task_stop sampled high while running gives eot_pulse = 1 for exactly one cycle after that edge, with eot_task equal to the running task's number. The block is then idle. task_stop while idle produces no pulse.
- R10: With oneshot high at the dispatch edge, the dispatched task's enable bit is 0 after that edge. This clear wins over a host enable write at the same edge.
- R11: en_wr high at an edge replaces the whole enable register with en_wdata after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_TASKS | Peripheral request, one bit per task |
| en_wr | input | 1 | Host write strobe for the enable register |
| en_wdata | input | NUM_TASKS | New enable register value |
| vec_wr | input | 1 | Host write strobe for one vector entry |
| vec_idx | input | ID_W | Vector entry to write |
| vec_wdata | input | PC_W | Start address to store |
| oneshot | input | 1 | Clear a task's enable bit when it launches |
| task_stop | input | 1 | Core strobe: running task reached its stop instruction |
| launch_ready | input | 1 | Core accepts the offered launch |
| launch_valid | output | 1 | Launch offer present |
| launch_id | output | ID_W | Offered or running task number |
| launch_pc | output | PC_W | Start address of the offered task |
| busy | output | 1 | A task is offered or running |
| eot_pulse | output | 1 | One-cycle end-of-task interrupt to the host |
| eot_task | output | ID_W | Task number belonging to eot_pulse |
| enable_o | output | NUM_TASKS | Current enable register |
| pending_o | output | NUM_TASKS | Current pending register |

## Verification
Each result has a fixed place in time. A request sampled at one edge shows in pending_o after that edge, and it can launch at the next edge at the earliest. A write to the enable register appears after its own edge. The end-of-task pulse follows the stop strobe's edge by one register stage and lasts one cycle. The bench drives inputs just after a falling edge and reads outputs at the next falling edge, so each check lands exactly one rising edge after its stimulus. Where a launch may come later, the bench polls launch_valid for a bounded number of cycles. An exhaustive sweep of all 255 request masks relies on this timing: the tasks are held disabled, then enabled, and the bench expects the launches in ascending bit order.

// File: rtl/td_pkg.sv
package td_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_RUN   = 2'd2
  } td_state_e;
endpackage

// File: rtl/td_pending.sv
module td_pending #(
  parameter int NUM_TASKS = 8,
  localparam int ID_W = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] irq_req,
  input  logic [NUM_TASKS-1:0] enable,
  input  logic                 disp,
  output logic [NUM_TASKS-1:0] pending,
  output logic                 pick_valid,
  output logic [ID_W-1:0]      pick_id
);
  logic [NUM_TASKS-1:0] cand;
  logic [NUM_TASKS-1:0] clr;

  assign cand = pending & enable;
  assign pick_valid = |cand;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    pick_id = '0;
    for (int i = NUM_TASKS - 1; i >= 0; i--) begin
      if (cand[i]) pick_id = ID_W'(i);
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_TASKS; g++) begin : g_pend
      assign clr[g] = disp && (pick_id == ID_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending[g] <= 1'b0;
        else        pending[g] <= (pending[g] && !clr[g]) || irq_req[g];
      end
    end
  endgenerate
endmodule

// File: rtl/td_vectors.sv
module td_vectors #(
  parameter int NUM_TASKS = 8,
  parameter int PC_W = 12,
  localparam int ID_W = $clog2(NUM_TASKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [ID_W-1:0] wr_idx,
  input  logic [PC_W-1:0] wr_data,
  input  logic [ID_W-1:0] rd_idx,
  output logic [PC_W-1:0] rd_data
);
  logic [PC_W-1:0] tbl [NUM_TASKS];

  genvar g;
  generate
    for (g = 0; g < NUM_TASKS; g++) begin : g_vec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               tbl[g] <= '0;
        else if (wr && (wr_idx == ID_W'(g)))      tbl[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = tbl[rd_idx];
endmodule

// File: rtl/td_ctrl.sv
module td_ctrl
  import td_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int PC_W = 12,
  localparam int ID_W = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_wr,
  input  logic [NUM_TASKS-1:0] en_wdata,
  input  logic                 oneshot,
  input  logic                 task_stop,
  input  logic                 launch_ready,
  input  logic                 pick_valid,
  input  logic [ID_W-1:0]      pick_id,
  input  logic [PC_W-1:0]      pick_pc,
  output logic                 disp,
  output logic [NUM_TASKS-1:0] enable,
  output logic                 launch_valid,
  output logic [ID_W-1:0]      launch_id,
  output logic [PC_W-1:0]      launch_pc,
  output logic                 busy,
  output logic                 eot_pulse,
  output logic [ID_W-1:0]      eot_task
);
  td_state_e            state_q, state_n;
  logic [NUM_TASKS-1:0] en_n;
  logic                 finish;

  assign disp   = (state_q == ST_IDLE) && pick_valid;
  assign finish = (state_q == ST_RUN) && task_stop;

  always_comb begin
    en_n = en_wr ? en_wdata : enable;
    if (disp && oneshot) en_n[pick_id] = 1'b0;
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (disp) state_n = ST_OFFER;
      ST_OFFER: if (launch_ready) state_n = ST_RUN;
      ST_RUN:   if (task_stop) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      enable    <= '0;
      launch_id <= '0;
      launch_pc <= '0;
      eot_pulse <= 1'b0;
      eot_task  <= '0;
    end else begin
      state_q   <= state_n;
      enable    <= en_n;
      eot_pulse <= finish;
      if (finish) eot_task <= launch_id;
      if (disp) begin
        launch_id <= pick_id;
        launch_pc <= pick_pc;
      end
    end
  end

  assign launch_valid = (state_q == ST_OFFER);
  assign busy         = (state_q != ST_IDLE);
endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher #(
  parameter int NUM_TASKS = 8,
  parameter int PC_W = 12,
  localparam int ID_W = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] irq_req,
  input  logic                 en_wr,
  input  logic [NUM_TASKS-1:0] en_wdata,
  input  logic                 vec_wr,
  input  logic [ID_W-1:0]      vec_idx,
  input  logic [PC_W-1:0]      vec_wdata,
  input  logic                 oneshot,
  input  logic                 task_stop,
  input  logic                 launch_ready,
  output logic                 launch_valid,
  output logic [ID_W-1:0]      launch_id,
  output logic [PC_W-1:0]      launch_pc,
  output logic                 busy,
  output logic                 eot_pulse,
  output logic [ID_W-1:0]      eot_task,
  output logic [NUM_TASKS-1:0] enable_o,
  output logic [NUM_TASKS-1:0] pending_o
);
  logic            disp;
  logic            pick_valid;
  logic [ID_W-1:0] pick_id;
  logic [PC_W-1:0] pick_pc;

  td_pending #(.NUM_TASKS(NUM_TASKS)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .enable(enable_o),
    .disp(disp), .pending(pending_o), .pick_valid(pick_valid), .pick_id(pick_id)
  );

  td_vectors #(.NUM_TASKS(NUM_TASKS), .PC_W(PC_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr(vec_wr), .wr_idx(vec_idx),
    .wr_data(vec_wdata), .rd_idx(pick_id), .rd_data(pick_pc)
  );

  td_ctrl #(.NUM_TASKS(NUM_TASKS), .PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .oneshot(oneshot), .task_stop(task_stop), .launch_ready(launch_ready),
    .pick_valid(pick_valid), .pick_id(pick_id), .pick_pc(pick_pc),
    .disp(disp), .enable(enable_o), .launch_valid(launch_valid),
    .launch_id(launch_id), .launch_pc(launch_pc), .busy(busy),
    .eot_pulse(eot_pulse), .eot_task(eot_task)
  );
endmodule

// File: rtl/td_checker.sv
module td_checker #(
  parameter int NUM_TASKS = 8,
  parameter int PC_W = 12,
  localparam int ID_W = $clog2(NUM_TASKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 oneshot,
  input logic                 task_stop,
  input logic                 launch_ready,
  input logic                 launch_valid,
  input logic [ID_W-1:0]      launch_id,
  input logic [PC_W-1:0]      launch_pc,
  input logic                 busy,
  input logic                 eot_pulse,
  input logic [ID_W-1:0]      eot_task,
  input logic [NUM_TASKS-1:0] enable_o,
  input logic [NUM_TASKS-1:0] pending_o
);
  logic [NUM_TASKS-1:0] en_d, pd_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= '0;
      pd_d <= '0;
    end else begin
      en_d <= enable_o;
      pd_d <= pending_o;
    end
  end

  AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(launch_valid) |-> (en_d[launch_id] && pd_d[launch_id])); // R3

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && !launch_ready) |=> (launch_valid && $stable(launch_pc) && $stable(launch_id))); // R7

  AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch_valid && !task_stop) |=> (busy && !launch_valid && $stable(launch_id))); // R8

  AST_EOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |-> ($past(task_stop) && $past(busy && !launch_valid) && eot_task == $past(launch_id))); // R9

  AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |=> !eot_pulse); // R9

  AST_ONESHOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(launch_valid) && $past(oneshot)) |-> !enable_o[launch_id]); // R10
endmodule

bind task_dispatcher td_checker #(.NUM_TASKS(NUM_TASKS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oneshot(oneshot), .task_stop(task_stop),
  .launch_ready(launch_ready), .launch_valid(launch_valid), .launch_id(launch_id),
  .launch_pc(launch_pc), .busy(busy), .eot_pulse(eot_pulse), .eot_task(eot_task),
  .enable_o(enable_o), .pending_o(pending_o)
);

// File: tb/tb_task_dispatcher.sv
module tb_task_dispatcher;
  localparam int N = 8;
  localparam int PW = 12;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic en_wr = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic vec_wr = 1'b0;
  logic [IW-1:0] vec_idx = '0;
  logic [PW-1:0] vec_wdata = '0;
  logic oneshot = 1'b0;
  logic task_stop = 1'b0;
  logic launch_ready = 1'b0;
  logic launch_valid, busy, eot_pulse;
  logic [IW-1:0] launch_id, eot_task;
  logic [PW-1:0] launch_pc;
  logic [N-1:0] enable_o, pending_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  task_dispatcher #(.NUM_TASKS(N), .PC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_wr(en_wr), .en_wdata(en_wdata),
    .vec_wr(vec_wr), .vec_idx(vec_idx), .vec_wdata(vec_wdata), .oneshot(oneshot),
    .task_stop(task_stop), .launch_ready(launch_ready), .launch_valid(launch_valid),
    .launch_id(launch_id), .launch_pc(launch_pc), .busy(busy), .eot_pulse(eot_pulse),
    .eot_task(eot_task), .enable_o(enable_o), .pending_o(pending_o)
  );

  function automatic logic [PW-1:0] vec_of(input int t);
    return PW'((t * 37 + 5) % (1 << PW));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_en(input logic [N-1:0] v);
    en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0;
  endtask

  task automatic pulse_irq(input logic [N-1:0] m);
    irq_req = m; tick(); irq_req = '0;
  endtask

  task automatic run_task(input int exp);
    int w = 0;
    while (!launch_valid && w < 20) begin tick(); w++; end
    chk("R4 launch_id", 32'(launch_id), 32'(exp));
    chk("R6 launch_pc", 32'(launch_pc), 32'(vec_of(exp)));
    launch_ready = 1'b1; tick(); launch_ready = 1'b0;
    chk("R8 running {busy,valid}", {30'd0, busy, launch_valid}, 32'b10);
    task_stop = 1'b1; tick(); task_stop = 1'b0;
    chk("R9 eot {pulse,task}", {28'd0, eot_pulse, eot_task}, {28'd0, 1'b1, 3'(exp)});
    tick();
    chk("R9 eot single cycle", 32'(eot_pulse), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 reset outputs", {29'd0, launch_valid, busy, eot_pulse}, 32'd0);
    chk("R1 reset regs", {16'd0, pending_o, enable_o}, 32'd0);
    rst_n = 1'b1; tick();

    // R6 program vectors
    for (int t = 0; t < N; t++) begin
      vec_wr = 1'b1; vec_idx = IW'(t); vec_wdata = vec_of(t); tick();
    end
    vec_wr = 1'b0;

    // R11 enable write
    write_en(8'h5A);
    chk("R11 enable write", 32'(enable_o), 32'h5A);
    write_en('0);

    // R9 stop while idle
    task_stop = 1'b1; tick(); task_stop = 1'b0; tick();
    chk("R9 idle stop ignored", {30'd0, eot_pulse, busy}, 32'd0);

    // R2/R3 timing with single task and each vector
    write_en('1);
    for (int t = 0; t < N; t++) begin
      pulse_irq(N'(1) << t);
      chk("R2 pending set", 32'(pending_o), 32'(N'(1) << t));
      chk("R3 no launch yet", 32'(launch_valid), 32'd0);
      tick();
      chk("R3 launch after dispatch", 32'(launch_valid), 32'd1);
      chk("R5 pending cleared", 32'(pending_o), 32'd0);
      run_task(t);
    end

    // R2 R3 R4 R5 exhaustive masks: latch while disabled, then release
    for (int m = 1; m < (1 << N); m++) begin
      write_en('0);
      pulse_irq(N'(m));
      tick(); tick();
      chk("R2 pending held while disabled", 32'(pending_o), 32'(m));
      chk("R3 no launch while disabled", 32'(launch_valid), 32'd0);
      write_en('1);
      for (int b = 0; b < N; b++) begin
        if (m[b]) run_task(b);
      end
      tick();
      chk("R5 all pending drained", 32'(pending_o), 32'd0);
    end

    // R7 back-pressure: offer holds, stop ignored while offered
    pulse_irq(8'h08); tick();
    for (int k = 0; k < 5; k++) begin
      task_stop = (k == 2);
      tick();
      chk("R7 offer held {valid,id,pc}", {16'd0, launch_valid, launch_id, launch_pc},
          {16'd0, 1'b1, 3'd3, vec_of(3)});
      chk("R7 stop during offer ignored", 32'(eot_pulse), 32'd0);
    end
    task_stop = 1'b0;
    run_task(3);

    // R8 no nesting: higher-priority request during run only pends
    pulse_irq(8'h02); tick();
    launch_ready = 1'b1; tick(); launch_ready = 1'b0;
    pulse_irq(8'h01); tick(); tick();
    chk("R8 no nest {busy,valid,id}", {28'd0, busy, launch_valid, launch_id}, {28'd0, 1'b1, 1'b0, 3'd1});
    chk("R8 request pends", 32'(pending_o), 32'h01);
    task_stop = 1'b1; tick(); task_stop = 1'b0;
    chk("R9 eot of running task", {28'd0, eot_pulse, eot_task}, {28'd0, 1'b1, 3'd1});
    tick();
    run_task(0);

    // R5 request at dispatch edge keeps pending bit
    write_en(8'h04);
    pulse_irq(8'h04);
    irq_req = 8'h04; tick(); irq_req = '0;
    chk("R5 same-edge request re-pends", 32'(pending_o), 32'h04);
    chk("R5 dispatched", 32'(launch_valid), 32'd1);
    run_task(2);
    run_task(2);

    // R10 one-shot clears enable, beating a same-edge host write
    oneshot = 1'b1;
    write_en('1);
    pulse_irq(8'h20);
    en_wr = 1'b1; en_wdata = '1; tick(); en_wr = 1'b0;
    chk("R10 oneshot clear beats write", 32'(enable_o), 32'hDF);
    run_task(5);
    pulse_irq(8'h20); tick(); tick();
    chk("R10 disabled after one-shot", 32'(launch_valid), 32'd0);
    oneshot = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule